// File: doc/BRIEF.md
# Trigger Configuration Register Bank

This block holds the configuration of a trigger controller. A host-side agent presents write strobes that each carry an address and a 32-bit value, and it reads back through a separate combinational read port addressed independently. Most addresses are plain storage: the written value is kept and driven continuously to the trigger logic.

A few addresses cause an action instead of storing data. One emits a single-cycle latch strobe. Another arms a software-trigger countdown that fires a one-cycle trigger pulse a fixed number of clocks later, provided software triggering is enabled. One control/status word has three write addresses: one overwrites it, one sets selected bits and one clears selected bits. The individual enable flags of the trigger-enable word are also brought out as separate named outputs.

Top module: `trig_cfg_regs`

## Requirements
- R1: A write to a storage address (0x20 output width, 0x21 busy width, 0x22 pulser width, 0x23 pulser period, 0x25 enable word, 0x29 NIM mask, 0x2A eSATA mask, 0x2C..0x2F coincidence words a..d) is visible on its output and on a read of the same address from the clock edge that accepts the write.
- R2: A read of 0x1F returns the BUILD_ID parameter; writes to 0x1F have no effect.
- R3: A write to 0x24, whatever its data, loads the software-trigger countdown with SW_PRELOAD (default 10); the count falls by one per clock while nonzero, and the trigger pulse is high during the single cycle in which the count is 1, i.e. the ninth cycle after the write edge with the default preload.
- R4: The software-trigger pulse is produced only when bit 0 of the enable word is 1; with bit 0 at 0 the countdown runs but no pulse appears.
- R5: A write to 0x2B, whatever its data, raises the latch strobe for exactly the one cycle after the write edge.
- R6: The control word is overwritten by a write to 0x3F, has the data's 1 bits set by a write to 0x3E and has the data's 1 bits cleared by a write to 0x3D; a read of 0x3F returns it.
- R7: Decoded enable outputs follow the enable word: bit 0 software trigger, bit 1 pulser, bit 3 run pulser, bit 4 pulser output, bits 8..11 multiplicity at least 1..4 (mult_en[0..3]), bit 13 UDP send, bit 14 busy, bits 16..19 coincidence groups a..d (coinc_en[0..3]).
- R8: Reads of 0x24, 0x2B, 0x3D, 0x3E and of any unmapped address return zero.
- R9: A synchronous reset clears every register to zero and cancels any pending latch strobe or countdown.
- R10: A write to 0x24 while a countdown is running restarts it from SW_PRELOAD.

Top module port order below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write value |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read value, combinational |
| out_width | output | 32 | Trigger output width |
| busy_width | output | 32 | Busy width |
| pulser_width | output | 32 | Pulser pulse width |
| pulser_period | output | 32 | Pulser period |
| enable_word | output | 32 | Trigger enable word |
| nim_mask | output | 32 | NIM input mask |
| esata_mask | output | 32 | eSATA input mask |
| coinc_a | output | 32 | Coincidence word a |
| coinc_b | output | 32 | Coincidence word b |
| coinc_c | output | 32 | Coincidence word c |
| coinc_d | output | 32 | Coincidence word d |
| ctl_word | output | 32 | Control/status word |
| latch_pulse | output | 1 | One-cycle latch strobe |
| sw_trig_pulse | output | 1 | Software trigger pulse |
| en_sw_trig | output | 1 | Software trigger enable |
| en_pulser | output | 1 | Pulser enable |
| run_pulser | output | 1 | Run pulser |
| pulser_out | output | 1 | Drive pulser output |
| mult_en | output | 4 | Multiplicity thresholds 1..4 enable |
| udp_en | output | 1 | UDP send enable |
| busy_en | output | 1 | Busy enable |
| coinc_en | output | 4 | Coincidence groups a..d enable |

## Verification
On every cycle the assertions check that the countdown falls by exactly one when not reloaded, that the trigger pulse never lasts beyond one cycle without a reload, that every latch strobe follows a write to its address, that set and clear writes leave the addressed bits in the right state, that the identifier reads back constant, and that registers are empty after reset. The exact pulse position, the gating by enable bit 0, the restart of a running countdown, the decoded bit positions, zero reads of strobe and unmapped addresses and the cancellation by reset are shown only by the bench's directed scenarios.

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs #(
  parameter int          ADDR_W     = 12,
  parameter logic [31:0] BUILD_ID   = 32'h5A7A_3FBD,
  parameter int          SW_PRELOAD = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [31:0]       out_width,
  output logic [31:0]       busy_width,
  output logic [31:0]       pulser_width,
  output logic [31:0]       pulser_period,
  output logic [31:0]       enable_word,
  output logic [31:0]       nim_mask,
  output logic [31:0]       esata_mask,
  output logic [31:0]       coinc_a,
  output logic [31:0]       coinc_b,
  output logic [31:0]       coinc_c,
  output logic [31:0]       coinc_d,
  output logic [31:0]       ctl_word,
  output logic              latch_pulse,
  output logic              sw_trig_pulse,
  output logic              en_sw_trig,
  output logic              en_pulser,
  output logic              run_pulser,
  output logic              pulser_out,
  output logic [3:0]        mult_en,
  output logic              udp_en,
  output logic              busy_en,
  output logic [3:0]        coinc_en
);

  localparam int CNT_W = $clog2(SW_PRELOAD + 1);
  localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'('h1F);
  localparam logic [ADDR_W-1:0] A_OWID  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_BWID  = ADDR_W'('h21);
  localparam logic [ADDR_W-1:0] A_PWID  = ADDR_W'('h22);
  localparam logic [ADDR_W-1:0] A_PPER  = ADDR_W'('h23);
  localparam logic [ADDR_W-1:0] A_SWT   = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'('h25);
  localparam logic [ADDR_W-1:0] A_NIM   = ADDR_W'('h29);
  localparam logic [ADDR_W-1:0] A_ESATA = ADDR_W'('h2A);
  localparam logic [ADDR_W-1:0] A_LATCH = ADDR_W'('h2B);
  localparam logic [ADDR_W-1:0] A_CA    = ADDR_W'('h2C);
  localparam logic [ADDR_W-1:0] A_CB    = ADDR_W'('h2D);
  localparam logic [ADDR_W-1:0] A_CC    = ADDR_W'('h2E);
  localparam logic [ADDR_W-1:0] A_CD    = ADDR_W'('h2F);
  localparam logic [ADDR_W-1:0] A_CCLR  = ADDR_W'('h3D);
  localparam logic [ADDR_W-1:0] A_CSET  = ADDR_W'('h3E);
  localparam logic [ADDR_W-1:0] A_CWR   = ADDR_W'('h3F);

  logic [CNT_W-1:0] swt_cnt;
  wire swt_load = wr_en && (wr_addr == A_SWT);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_width <= '0; busy_width <= '0; pulser_width <= '0; pulser_period <= '0;
      enable_word <= '0; nim_mask <= '0; esata_mask <= '0;
      coinc_a <= '0; coinc_b <= '0; coinc_c <= '0; coinc_d <= '0;
      ctl_word <= '0; latch_pulse <= 1'b0; swt_cnt <= '0;
    end else begin
      latch_pulse <= wr_en && (wr_addr == A_LATCH);
      if (swt_load)         swt_cnt <= CNT_W'(SW_PRELOAD);
      else if (swt_cnt != 0) swt_cnt <= swt_cnt - 1'b1;
      if (wr_en) begin
        case (wr_addr)
          A_OWID:  out_width     <= wr_data;
          A_BWID:  busy_width    <= wr_data;
          A_PWID:  pulser_width  <= wr_data;
          A_PPER:  pulser_period <= wr_data;
          A_EN:    enable_word   <= wr_data;
          A_NIM:   nim_mask      <= wr_data;
          A_ESATA: esata_mask    <= wr_data;
          A_CA:    coinc_a       <= wr_data;
          A_CB:    coinc_b       <= wr_data;
          A_CC:    coinc_c       <= wr_data;
          A_CD:    coinc_d       <= wr_data;
          A_CCLR:  ctl_word      <= ctl_word & ~wr_data;
          A_CSET:  ctl_word      <= ctl_word | wr_data;
          A_CWR:   ctl_word      <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_ID:    rd_data = BUILD_ID;
      A_OWID:  rd_data = out_width;
      A_BWID:  rd_data = busy_width;
      A_PWID:  rd_data = pulser_width;
      A_PPER:  rd_data = pulser_period;
      A_EN:    rd_data = enable_word;
      A_NIM:   rd_data = nim_mask;
      A_ESATA: rd_data = esata_mask;
      A_CA:    rd_data = coinc_a;
      A_CB:    rd_data = coinc_b;
      A_CC:    rd_data = coinc_c;
      A_CD:    rd_data = coinc_d;
      A_CWR:   rd_data = ctl_word;
      default: rd_data = '0;
    endcase
  end

  assign sw_trig_pulse = (swt_cnt == CNT_W'(1)) && enable_word[0];

  assign en_sw_trig = enable_word[0];
  assign en_pulser  = enable_word[1];
  assign run_pulser = enable_word[3];
  assign pulser_out = enable_word[4];
  assign mult_en    = enable_word[11:8];
  assign udp_en     = enable_word[13];
  assign busy_en    = enable_word[14];
  assign coinc_en   = enable_word[19:16];

  p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
    (swt_cnt != 0 && !swt_load) |=> swt_cnt == $past(swt_cnt) - 1'b1);

  p_single_trig_r3: assert property (@(posedge clk) disable iff (rst)
    (sw_trig_pulse && !swt_load) |=> !sw_trig_pulse);

  p_latch_src_r5: assert property (@(posedge clk) disable iff (rst)
    latch_pulse |-> $past(wr_en && wr_addr == A_LATCH));

  p_set_bits_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CSET) |=> (ctl_word & $past(wr_data)) == $past(wr_data));

  p_clr_bits_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CCLR) |=> (ctl_word & $past(wr_data)) == 32'h0);

  p_build_id_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_ID) |-> rd_data == BUILD_ID);

  p_reset_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> (swt_cnt == 0 && !latch_pulse && ctl_word == 32'h0 && enable_word == 32'h0));

endmodule

// File: tb/sim_trig_cfg_regs.sv
`timescale 1ns/1ps
module sim_trig_cfg_regs;
  localparam int AW = 12;
  localparam logic [31:0] ID = 32'h5A7A_3FBD;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [31:0] out_width, busy_width, pulser_width, pulser_period, enable_word;
  logic [31:0] nim_mask, esata_mask, coinc_a, coinc_b, coinc_c, coinc_d, ctl_word;
  logic latch_pulse, sw_trig_pulse, en_sw_trig, en_pulser, run_pulser, pulser_out, udp_en, busy_en;
  logic [3:0] mult_en, coinc_en;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  trig_cfg_regs #(.ADDR_W(AW), .BUILD_ID(ID), .SW_PRELOAD(10)) u0 (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .out_width, .busy_width, .pulser_width, .pulser_period, .enable_word,
    .nim_mask, .esata_mask, .coinc_a, .coinc_b, .coinc_c, .coinc_d, .ctl_word,
    .latch_pulse, .sw_trig_pulse, .en_sw_trig, .en_pulser, .run_pulser,
    .pulser_out, .mult_en, .udp_en, .busy_en, .coinc_en);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  function automatic logic [31:0] rd(logic [AW-1:0] a);
    rd_addr = a;
    return 32'h0;
  endfunction

  task automatic rdchk(string req, logic [AW-1:0] a, logic [31:0] exp);
    logic [31:0] dummy;
    dummy = rd(a);
    #0.5;
    chk(req, rd_data, exp);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 reset ctl", ctl_word, 0);
    chk("R9 reset enable", enable_word, 0);
    chk("R9 reset latch", {31'h0, latch_pulse}, 0);
  endtask

  task automatic t_storage;
    logic [AW-1:0] addrs [11] = '{'h20,'h21,'h22,'h23,'h25,'h29,'h2A,'h2C,'h2D,'h2E,'h2F};
    for (int i = 0; i < 11; i++) wr(addrs[i], 32'h1000_0000 + 32'(i) * 32'h0101_0101);
    for (int i = 0; i < 11; i++) rdchk("R1 readback", addrs[i], 32'h1000_0000 + 32'(i) * 32'h0101_0101);
    chk("R1 out_width", out_width, 32'h1000_0000);
    chk("R1 pulser_period", pulser_period, 32'h1303_0303);
    chk("R1 nim_mask", nim_mask, 32'h1505_0505);
    chk("R1 coinc_d", coinc_d, 32'h1A0A_0A0A);
    wr('h20, 32'hDEAD_BEEF);
    chk("R1 out_width update", out_width, 32'hDEAD_BEEF);
  endtask

  task automatic t_build_id;
    wr('h1F, 32'h0);
    rdchk("R2 id", 'h1F, ID);
  endtask

  task automatic t_countdown(bit en, string req);
    wr('h25, {31'h0, en});
    wr('h24, 32'h0000_0000);
    chk(req, {31'h0, sw_trig_pulse}, 0);
    for (int j = 1; j <= 11; j++) begin
      @(negedge clk);
      chk(req, {31'h0, sw_trig_pulse}, {31'h0, en && (j == 9)});
    end
  endtask

  task automatic t_restart;
    wr('h25, 32'h1);
    wr('h24, 32'hFFFF_FFFF);
    repeat (5) @(negedge clk);
    wr('h24, 32'h0);
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      chk("R10 restart", {31'h0, sw_trig_pulse}, {31'h0, j == 9});
    end
  endtask

  task automatic t_latch;
    chk("R5 idle", {31'h0, latch_pulse}, 0);
    wr('h2B, 32'h0);
    chk("R5 high", {31'h0, latch_pulse}, 1);
    @(negedge clk);
    chk("R5 low", {31'h0, latch_pulse}, 0);
  endtask

  task automatic t_ctl;
    wr('h3F, 32'hF0F0_0000);
    rdchk("R6 overwrite", 'h3F, 32'hF0F0_0000);
    wr('h3E, 32'h0000_00FF);
    chk("R6 set", ctl_word, 32'hF0F0_00FF);
    wr('h3D, 32'hF000_000F);
    chk("R6 clear", ctl_word, 32'h00F0_00F0);
  endtask

  task automatic t_enables;
    wr('h25, 32'h000A_2519);
    chk("R7 sw", {31'h0, en_sw_trig}, 1);
    chk("R7 pulser", {31'h0, en_pulser}, 0);
    chk("R7 run", {31'h0, run_pulser}, 1);
    chk("R7 out", {31'h0, pulser_out}, 1);
    chk("R7 mult", {28'h0, mult_en}, 4'b0101);
    chk("R7 udp", {31'h0, udp_en}, 1);
    chk("R7 busy", {31'h0, busy_en}, 0);
    chk("R7 coinc", {28'h0, coinc_en}, 4'b1010);
    wr('h25, 32'hFFF5_DAE6);
    chk("R7 inverse", {19'h0, coinc_en, busy_en, udp_en, mult_en, pulser_out, run_pulser, en_pulser, en_sw_trig},
        {19'h0, 4'b0101, 1'b1, 1'b0, 4'b1010, 1'b0, 1'b0, 1'b1, 1'b0});
  endtask

  task automatic t_zero_reads;
    rdchk("R8 swt", 'h24, 0);
    rdchk("R8 latch", 'h2B, 0);
    rdchk("R8 clr", 'h3D, 0);
    rdchk("R8 set", 'h3E, 0);
    rdchk("R8 unmapped", 'h26, 0);
    rdchk("R8 unmapped high", 'hABC, 0);
  endtask

  task automatic t_reset_cancel;
    wr('h25, 32'h1);
    wr('h24, 32'h0);
    @(negedge clk); wr_en = 1'b1; wr_addr = 'h2B;
    @(negedge clk); wr_en = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 latch cancelled", {31'h0, latch_pulse}, 0);
    chk("R9 enable cleared", enable_word, 0);
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      chk("R9 countdown cancelled", {31'h0, sw_trig_pulse}, 0);
    end
  endtask

  initial begin
    t_reset();
    t_storage();
    t_build_id();
    t_countdown(1'b1, "R3 pulse timing");
    t_countdown(1'b0, "R4 gated off");
    t_restart();
    t_latch();
    t_ctl();
    t_enables();
    t_zero_reads();
    t_reset_cancel();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule